// File: doc/BRIEF.md
# Digital Phase-Locked Loop Core

This block contains the complete loop of a first-order, all-digital phase-locked loop, apart from the feedback divider. A reference square wave and the divided-down feedback signal go to a phase detector. The detector can be an exclusive-OR comparator or an edge-triggered set/reset comparator, chosen by a select input. The detector output sets the direction of an up/down counter whose length can be programmed. The counter steps on a counter-clock enable strobe. When it wraps past its top value it emits a carry pulse, and when it wraps below zero it emits a borrow pulse.

Those pulses steer an increment/decrement stage. That stage divides an I/D-clock enable strobe by two to form the loop output. Each carry pulls the next output edge one strobe earlier, and each borrow pushes it one strobe later. The loop output goes to an external divide-by-N counter, and that counter's output returns as the feedback input. A 4-bit length code picks the counter modulus at run time, so software can trade loop bandwidth against lock time while the loop is running.

The block runs on a single system clock and a synchronous, active-high reset. Both timing sources enter as enable strobes.

Top module: `dpll_core`

## Requirements
- R1: With `det_sel`=0 (exclusive-OR mode), `pd_out` equals `ref_in` XOR `fb_in` in the same cycle, with no register in the path.
- R2: With `det_sel`=1 (edge mode), a rising edge on `ref_in` alone sets `pd_out` to 1 on the following cycle. A rising edge on `fb_in` alone clears it to 0 on the following cycle. When both rise together, or when neither rises, `pd_out` keeps its value.
- R3: Length code 0 freezes the counter. It keeps its value, and `carry_o` and `borrow_o` stay low.
- R4: A nonzero length code n gives the counter a modulus of 2^(n+2). Code 1 gives 8, and code 15 gives 2^17.
- R5: On each `kclk_en` strobe, the counter counts up when `pd_out`=1 and down when `pd_out`=0. Stepping up from the top value returns it to 0 and raises `carry_o` for exactly one cycle, starting on the cycle after that strobe. Stepping down from 0 moves it to the top value and raises `borrow_o` in the same way. Both pulses stay low on any cycle that follows a cycle without a strobe.
- R6: The length code may change while the loop runs. The counter keeps its value reduced to the new modulus and carries on counting without a reset.
- R7: With no correction pending, `id_out` toggles on every second `idclk_en` strobe. Starting from reset, the first toggle comes on the second strobe. Without a strobe, `id_out` holds.
- R8: A carry pulse is stored until the next `idclk_en` strobe, and that strobe toggles `id_out` at once. A stored borrow makes the next strobe a null step, which delays the following toggle by one strobe. A stored carry and a stored borrow cancel each other out.
- R9: Reset clears the counter, the edge detector, the stored corrections and `id_out`. After reset, all registered outputs read 0.
- R10: The loop must lock on 50%-duty square waves. Test setup: exclusive-OR mode, code 1, both strobes held high, an external divide-by-8, and a reference period of 30 cycles against a free-running feedback period of 32 cycles. Under this setup, the rising-edge counts of the feedback and the reference over a long window differ by at most 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal to the phase detector |
| fb_in | input | 1 | Feedback signal from the external divider |
| det_sel | input | 1 | Phase detector select: 0 exclusive-OR, 1 edge |
| len_code | input | CODE_W | Counter length code (0 freezes the counter) |
| kclk_en | input | 1 | Counter step strobe |
| idclk_en | input | 1 | I/D stage step strobe |
| pd_out | output | 1 | Phase detector output (counter direction) |
| carry_o | output | 1 | One-cycle pulse on wrap past the top value |
| borrow_o | output | 1 | One-cycle pulse on wrap below zero |
| id_out | output | 1 | Loop output, goes to the external divider |

## Verification
Each result has a fixed latency, and the checks are placed to match it. `pd_out` in exclusive-OR mode is combinational, so it is read at the falling edge of the same cycle in which the inputs change. The edge-mode `pd_out`, `carry_o` and `borrow_o` are each one register away, so they are read at the falling edge that follows the rising edge that used the stimulus. The counter modulus is measured as the number of strobed rising edges before `carry_o` is first seen at a falling edge. A carry or borrow needs one more cycle to be stored before it can act on `id_out`. The bench therefore waits one idle cycle before issuing `idclk_en` strobes, and reads `id_out` one falling edge after each strobe.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic {
    PD_XOR  = 1'b0,
    PD_EDGE = 1'b1
  } pd_mode_e;

  // Top value of the counter for a length code: 2^(code+2)-1, or 0 when frozen.
  function automatic logic [31:0] stage_mask(input logic [7:0] code);
    logic [31:0] m;
    if (code == 8'd0) m = 32'd0;
    else              m = (32'd1 << (code + 8'd2)) - 32'd1;
    return m;
  endfunction

  // Phase advance applied by one I/D strobe: 2 after a carry, 0 after a borrow, else 1.
  function automatic logic [1:0] id_step(input logic adv, input logic ret);
    logic [1:0] s;
    if (adv && !ret)      s = 2'd2;
    else if (ret && !adv) s = 2'd0;
    else                  s = 2'd1;
    return s;
  endfunction

endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
  import dpll_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic sel,
  output logic pd,
  output logic ref_rise,
  output logic fb_rise
);

  logic ref_d, fb_d, edge_q;

  assign ref_rise = ref_in & ~ref_d;
  assign fb_rise  = fb_in & ~fb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d  <= 1'b0;
      fb_d   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
      if (ref_rise && !fb_rise)      edge_q <= 1'b1;
      else if (fb_rise && !ref_rise) edge_q <= 1'b0;
    end
  end

  always_comb begin
    if (pd_mode_e'(sel) == PD_EDGE) pd = edge_q;
    else                            pd = ref_in ^ fb_in;
  end

endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter
  import dpll_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              up,
  input  logic [CODE_W-1:0] code,
  output logic              carry,
  output logic              borrow
);

  logic [CNT_W-1:0] cnt_q, mask, cnt_m;
  logic             active, at_top, at_bot;

  assign mask   = CNT_W'(stage_mask(8'(code)));
  assign cnt_m  = cnt_q & mask;
  assign active = en && (code != '0);
  assign at_top = (cnt_m == mask);
  assign at_bot = (cnt_m == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else begin
      carry  <= active && up && at_top;
      borrow <= active && !up && at_bot;
      if (active) begin
        if (up) cnt_q <= at_top ? '0 : cnt_m + 1'b1;
        else    cnt_q <= at_bot ? mask : cnt_m - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dpll_idcirc.sv
module dpll_idcirc
  import dpll_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic carry,
  input  logic borrow,
  output logic out
);

  logic       pend_adv, pend_ret, half_q;
  logic [1:0] sum;

  assign sum = {1'b0, half_q} + id_step(pend_adv, pend_ret);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_adv <= 1'b0;
      pend_ret <= 1'b0;
      half_q   <= 1'b0;
      out      <= 1'b0;
    end else begin
      pend_adv <= carry  | (pend_adv & ~en);
      pend_ret <= borrow | (pend_ret & ~en);
      if (en) begin
        half_q <= sum[0];
        if (sum[1]) out <= ~out;
      end
    end
  end

endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int CODE_W = 4,
  localparam int CNT_W = (1 << CODE_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic              det_sel,
  input  logic [CODE_W-1:0] len_code,
  input  logic              kclk_en,
  input  logic              idclk_en,
  output logic              pd_out,
  output logic              carry_o,
  output logic              borrow_o,
  output logic              id_out
);

  logic ref_rise_w, fb_rise_w;

  dpll_phase_det u_pd (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .sel      (det_sel),
    .pd       (pd_out),
    .ref_rise (ref_rise_w),
    .fb_rise  (fb_rise_w)
  );

  dpll_kcounter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_kc (
    .clk    (clk),
    .rst    (rst),
    .en     (kclk_en),
    .up     (pd_out),
    .code   (len_code),
    .carry  (carry_o),
    .borrow (borrow_o)
  );

  dpll_idcirc u_id (
    .clk    (clk),
    .rst    (rst),
    .en     (idclk_en),
    .carry  (carry_o),
    .borrow (borrow_o),
    .out    (id_out)
  );

endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              det_sel,
  input logic [CODE_W-1:0] len_code,
  input logic              kclk_en,
  input logic              idclk_en,
  input logic              pd_out,
  input logic              carry_o,
  input logic              borrow_o,
  input logic              id_out,
  input logic              ref_rise,
  input logic              fb_rise
);

  p_frozen_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (len_code == '0) |=> (!carry_o && !borrow_o));

  p_no_strobe_no_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !kclk_en |=> (!carry_o && !borrow_o));

  p_carry_single_r5: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> !carry_o);

  p_borrow_single_r5: assert property (@(posedge clk) disable iff (rst)
    borrow_o |=> !borrow_o);

  p_id_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !idclk_en |=> $stable(id_out));

  p_edge_set_r2: assert property (@(posedge clk) disable iff (rst)
    (det_sel && ref_rise && !fb_rise) |=> (pd_out || !det_sel));

  p_edge_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (det_sel && fb_rise && !ref_rise) |=> (!pd_out || !det_sel));

endmodule

bind dpll_core dpll_core_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .det_sel  (det_sel),
  .len_code (len_code),
  .kclk_en  (kclk_en),
  .idclk_en (idclk_en),
  .pd_out   (pd_out),
  .carry_o  (carry_o),
  .borrow_o (borrow_o),
  .id_out   (id_out),
  .ref_rise (ref_rise_w),
  .fb_rise  (fb_rise_w)
);

// File: tb/dpll_core_tb.sv
module dpll_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0, fb_in = 1'b0, det_sel = 1'b0;
  logic [3:0] len_code = 4'd0;
  logic       kclk_en = 1'b0, idclk_en = 1'b0;
  logic       pd_out, carry_o, borrow_o, id_out;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dpll_core u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .det_sel(det_sel),
    .len_code(len_code), .kclk_en(kclk_en), .idclk_en(idclk_en),
    .pd_out(pd_out), .carry_o(carry_o), .borrow_o(borrow_o), .id_out(id_out)
  );

  // {length code, expected strobes from reset until the first carry}
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {4'd1, 32'd8}, {4'd2, 32'd16}, {4'd3, 32'd32},
    {4'd5, 32'd128}, {4'd8, 32'd1024}, {4'd13, 32'd32768}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; kclk_en = 1'b0; idclk_en = 1'b0;
    ref_in = 1'b0; fb_in = 1'b0; det_sel = 1'b0; len_code = 4'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_to_carry(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!carry_o && k < 70000);
  endtask

  task automatic id_pulse();
    idclk_en = 1'b1;
    @(negedge clk);
    idclk_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int k, bc, rr, fr, ph, div;
    logic idp, fbv, refp, fbp;

    // R9: reset state
    do_reset();
    #1;
    check("R9 carry", carry_o, 0);
    check("R9 borrow", borrow_o, 0);
    check("R9 id_out", id_out, 0);
    check("R9 pd_out", pd_out, 0);

    // R4/R5: modulus table, counting up from reset
    for (int v = 0; v < NV; v++) begin
      do_reset();
      len_code = VEC[v][35:32]; ref_in = 1'b1; fb_in = 1'b0; kclk_en = 1'b1;
      count_to_carry(k);
      check($sformatf("R4 R5 modulus code %0d", VEC[v][35:32]), k, int'(VEC[v][31:0]));
      @(negedge clk);
      check("R5 carry one cycle", carry_o, 0);
    end

    // R1: exclusive-OR detector, same cycle
    for (int p = 0; p < 4; p++) begin
      ref_in = p[1]; fb_in = p[0]; #1;
      check("R1 xor", pd_out, p[1] ^ p[0]);
    end

    // R2: edge detector
    do_reset();
    det_sel = 1'b1;
    @(negedge clk);
    ref_in = 1'b1; @(negedge clk); check("R2 ref rise sets", pd_out, 1);
    fb_in = 1'b1;  @(negedge clk); check("R2 fb rise clears", pd_out, 0);
    ref_in = 1'b0; fb_in = 1'b0; @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1; @(negedge clk); check("R2 both rise hold 0", pd_out, 0);
    ref_in = 1'b0; fb_in = 1'b0; @(negedge clk); check("R2 no edge hold", pd_out, 0);
    ref_in = 1'b1; @(negedge clk); check("R2 ref rise sets again", pd_out, 1);
    ref_in = 1'b0; @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1; @(negedge clk); check("R2 both rise hold 1", pd_out, 1);

    // R3: code 0 freezes the counter, then code 1 resumes from 0
    do_reset();
    ref_in = 1'b1; kclk_en = 1'b1; bc = 0;
    repeat (50) begin @(negedge clk); if (carry_o || borrow_o) bc++; end
    check("R3 no pulses while frozen", bc, 0);
    len_code = 4'd1;
    count_to_carry(k);
    check("R3 value held while frozen", k, 8);

    // R6: runtime length change
    do_reset();
    len_code = 4'd3; ref_in = 1'b1; kclk_en = 1'b1;
    repeat (20) @(negedge clk);
    len_code = 4'd1;
    count_to_carry(k);
    check("R6 carry after switch to code 1", k, 4);
    count_to_carry(k);
    check("R6 new modulus 8", k, 8);

    // R4/R5/R6: seventeen stages, counting down
    do_reset();
    len_code = 4'd15; kclk_en = 1'b1;
    @(negedge clk);
    check("R5 borrow below zero", borrow_o, 1);
    bc = 0;
    repeat (65536) begin @(negedge clk); if (borrow_o) bc++; end
    check("R4 no borrow inside 2^17 range", bc, 0);
    len_code = 4'd14; ref_in = 1'b1;
    @(negedge clk);
    check("R4 R6 17-bit value kept at 0xFFFF", carry_o, 1);

    // R7: plain divide by two
    do_reset();
    idclk_en = 1'b1;
    @(negedge clk); check("R7 strobe 1", id_out, 0);
    @(negedge clk); check("R7 strobe 2", id_out, 1);
    @(negedge clk); check("R7 strobe 3", id_out, 1);
    @(negedge clk); check("R7 strobe 4", id_out, 0);
    idclk_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", id_out, 0);

    // R8: carry advances
    do_reset();
    len_code = 4'd1; ref_in = 1'b1; kclk_en = 1'b1;
    repeat (8) @(negedge clk);
    kclk_en = 1'b0;
    @(negedge clk);
    id_pulse(); check("R8 carry toggles at first strobe", id_out, 1);
    id_pulse(); check("R8 after carry strobe 2", id_out, 1);
    id_pulse(); check("R8 after carry strobe 3", id_out, 0);

    // R8: borrow delays
    do_reset();
    len_code = 4'd1; kclk_en = 1'b1;
    @(negedge clk);
    kclk_en = 1'b0;
    @(negedge clk);
    id_pulse(); id_pulse(); check("R8 borrow delays toggle", id_out, 0);
    id_pulse(); check("R8 toggle after delay", id_out, 1);

    // R10: closed loop with external divide-by-8
    do_reset();
    len_code = 4'd1; kclk_en = 1'b1; idclk_en = 1'b1;
    ph = 0; div = 0; idp = 1'b0; fbv = 1'b0; refp = 1'b0; fbp = 1'b0; rr = 0; fr = 0;
    for (int c = 0; c < 9000; c++) begin
      ref_in = (ph < 15);
      ph = (ph == 29) ? 0 : ph + 1;
      fb_in = fbv;
      if (c >= 3000) begin
        if (ref_in && !refp) rr++;
        if (fb_in && !fbp) fr++;
      end
      refp = ref_in; fbp = fb_in;
      @(negedge clk);
      if (id_out && !idp) begin
        div++;
        if (div == 4) begin div = 0; fbv = ~fbv; end
      end
      idp = id_out;
    end
    check("R10 locked edge count difference within 2", (rr - fr > 2 || fr - rr > 2) ? 1 : 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule